// File: doc/BRIEF.md
# SPI Host Register and FIFO Front End

This block is the processor-facing half of an SPI master. Software reaches it over a simple 32-bit register bus: one access per cycle, with read data registered. It queues outgoing words in an 8-entry transmit FIFO and hands them, one at a time, to a serial shift engine through a valid/ready pair. Words the engine returns are collected in an 8-entry receive FIFO. Both FIFOs share a single data offset: a write pushes to transmit and a read pops from receive. Each FIFO can be flushed and has a 4-bit threshold.

Three sticky interrupt causes are kept: transmit-complete, receive-complete and receive overrun. Receive-complete fires when the receive FIFO count reaches the threshold that software programs for each burst. Interrupt status is read at the same offset where it is cleared by writing ones. A single interrupt line is the OR of the enabled causes. A global enable bit stops the handoff of new words to the engine.

The handoff to the engine is a two-state machine.
- `ST_IDLE` → `ST_OFFER`: taken when the enable is set and the transmit FIFO is not empty. A word is popped into a hold register.
- `ST_OFFER` → `ST_OFFER`: taken on an accepted handshake while more words are queued and the enable is still set. The next word is popped in the same cycle, so words go out back to back.
- `ST_OFFER` → `ST_IDLE`: taken on an accepted handshake when the FIFO is empty or the enable is clear.
- Each state holds while its exit condition is false.

Top module: `spi_host_regs`

## Requirements
- R1: All registers reset to 0. Bit 0 of offset 0x00 is the enable. Offsets 0x04, 0x08, 0x0C and 0x10 store and return all 32 bits. Offset 0x18 keeps bits 4, 3 and 0. Offset 0x20 returns the transmit threshold in bits 11:8 and the receive threshold in bits 3:0. Unmapped offsets read 0.
- R2: A write to 0x24 pushes into the 8-entry transmit FIFO. A push while it holds 8 words is dropped.
- R3: With the enable set, queued words are presented to the engine in FIFO order. While ready is low, `sh_tx_valid` and `sh_tx_word` hold their values.
- R4: While the enable is 0, no new word is presented to the engine.
- R5: A read of 0x24 pops the receive FIFO in arrival order. A read while it is empty returns 0 and removes nothing.
- R6: Bit 0 of status (0x14) is 1 exactly while the receive FIFO holds a word.
- R7: Writing offset 0x20 with bit 4 set empties the receive FIFO, and with bit 12 set empties the transmit FIFO. The flush bits read back as 0.
- R8: Receive-complete (bit 3 of 0x1C) is set when an arriving word makes the receive count equal the receive threshold. A threshold of 0 never sets it. Bit 9 reads 1 while the threshold is nonzero and the count is at least the threshold.
- R9: Overrun (bit 0 of 0x1C) is set when a word arrives while the receive FIFO holds 8 words. That word is discarded.
- R10: Transmit-complete (bit 4 of 0x1C) is set when the engine accepts a word and the transmit FIFO is empty.
- R11: Writing 1 to bit 4, 3 or 0 of 0x1C clears that cause. Writing 0 has no effect. A new event in the same cycle wins over the clear.
- R12: `irq` is 1 exactly when some cause in bits 4, 3 or 0 is set together with the enable bit at the same position in 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| sh_tx_valid | output | 1 | Word offered to the shift engine |
| sh_tx_ready | input | 1 | Engine accepts the offered word |
| sh_tx_word | output | 32 | Offered word |
| sh_rx_valid | input | 1 | Engine delivers a received word |
| sh_rx_word | input | 32 | Received word |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the engine pulses `sh_rx_valid` once for each word it delivers, and that `sh_tx_ready` may stay low for any number of cycles. They also assume that a threshold is not rewritten in the same cycle as a word arrives, although the receive-complete check does exclude that cycle. The bench respects these assumptions in two ways. Its loopback engine returns one word, one cycle after each accepted handshake. All configuration writes happen while the engine is quiet, after a settling wait. For the overrun and flush cases, the loopback is switched off and words are injected directly, so the receive FIFO can be filled past its depth without any transmit activity.

// File: rtl/shq_pkg.sv
package shq_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_CTRL = 6'h00;
    localparam logic [ADDR_W-1:0] A_CLK  = 6'h04;
    localparam logic [ADDR_W-1:0] A_TXW  = 6'h08;
    localparam logic [ADDR_W-1:0] A_RXW  = 6'h0C;
    localparam logic [ADDR_W-1:0] A_FRM  = 6'h10;
    localparam logic [ADDR_W-1:0] A_STAT = 6'h14;
    localparam logic [ADDR_W-1:0] A_IEN  = 6'h18;
    localparam logic [ADDR_W-1:0] A_IST  = 6'h1C;
    localparam logic [ADDR_W-1:0] A_FCTL = 6'h20;
    localparam logic [ADDR_W-1:0] A_DATA = 6'h24;

    localparam int B_TXFL = 12;
    localparam int B_RXFL = 4;
    localparam int B_TXC  = 4;
    localparam int B_RXC  = 3;
    localparam int B_OVR  = 0;
    localparam int B_RAW  = 9;
    localparam int THR_W  = 4;

    typedef enum logic {
        ST_IDLE,
        ST_OFFER
    } hand_st_t;
endpackage

// File: rtl/shq_fifo.sv
module shq_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush_i,
    input  logic                     push_i,
    input  logic                     pop_i,
    input  logic [WIDTH-1:0]         din_i,
    output logic [WIDTH-1:0]         dout_o,
    output logic [$clog2(DEPTH):0]   count_o,
    output logic                     empty_o,
    output logic                     full_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             push_ok, pop_ok;

    assign empty_o = (cnt == '0);
    assign full_o  = (cnt == CW'(DEPTH));
    assign push_ok = push_i && !full_o;
    assign pop_ok  = pop_i && !empty_o;
    assign dout_o  = mem[rp];
    assign count_o = cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush_i) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush_i) mem[wp] <= din_i;
    end

    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> empty_o);
endmodule

// File: rtl/shq_tx_hand.sv
module shq_tx_hand #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             fifo_empty_i,
    input  logic [WIDTH-1:0] fifo_word_i,
    output logic             fifo_pop_o,
    output logic             tx_valid_o,
    output logic [WIDTH-1:0] tx_word_o,
    input  logic             tx_ready_i,
    output logic             done_o
);
    import shq_pkg::*;

    hand_st_t         st, nxt;
    logic [WIDTH-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt        = st;
        fifo_pop_o = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (en_i && !fifo_empty_i) begin
                    fifo_pop_o = 1'b1;
                    nxt        = ST_OFFER;
                end
            end
            ST_OFFER: begin
                if (tx_ready_i) begin
                    if (en_i && !fifo_empty_i) begin
                        fifo_pop_o = 1'b1;
                        nxt        = ST_OFFER;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          hold_q <= '0;
        else if (fifo_pop_o) hold_q <= fifo_word_i;
    end

    assign tx_valid_o = (st == ST_OFFER);
    assign tx_word_o  = hold_q;
    assign done_o     = (st == ST_OFFER) && tx_ready_i && fifo_empty_i;

    assert_hold_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_word_o));

    assert_no_start_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i && !tx_valid_o |=> !tx_valid_o);
endmodule

// File: rtl/shq_csr.sv
module shq_csr #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel_i,
    input  logic                        bus_wr_i,
    input  logic [shq_pkg::ADDR_W-1:0]  bus_addr_i,
    input  logic [WIDTH-1:0]            bus_wdata_i,
    output logic [WIDTH-1:0]            bus_rdata_o,
    output logic                        en_o,
    output logic                        txf_push_o,
    output logic                        txf_flush_o,
    output logic                        rxf_pop_o,
    output logic                        rxf_flush_o,
    input  logic [WIDTH-1:0]            rx_head_i,
    input  logic [$clog2(DEPTH):0]      rx_count_i,
    input  logic                        rx_empty_i,
    input  logic                        rx_full_i,
    input  logic                        rx_valid_i,
    input  logic                        tx_done_i,
    output logic                        irq_o
);
    import shq_pkg::*;

    logic             wr_en, rd_en;
    logic             en_q;
    logic [WIDTH-1:0] clk_q, txw_q, rxw_q, frm_q;
    logic             ie_tc, ie_rc, ie_ov;
    logic             is_tc, is_rc, is_ov;
    logic [THR_W-1:0] tx_thr, rx_thr;
    logic             rx_acc, rc_set, raw_hit;
    logic [WIDTH-1:0] rv;
    int               nc;

    assign wr_en = bus_sel_i && bus_wr_i;
    assign rd_en = bus_sel_i && !bus_wr_i;

    assign txf_push_o  = wr_en && (bus_addr_i == A_DATA);
    assign rxf_pop_o   = rd_en && (bus_addr_i == A_DATA) && !rx_empty_i;
    assign txf_flush_o = wr_en && (bus_addr_i == A_FCTL) && bus_wdata_i[B_TXFL];
    assign rxf_flush_o = wr_en && (bus_addr_i == A_FCTL) && bus_wdata_i[B_RXFL];
    assign en_o        = en_q;

    always_comb begin
        nc      = int'(rx_count_i) + 1 - (rxf_pop_o ? 1 : 0);
        rx_acc  = rx_valid_i && !rx_full_i && !rxf_flush_o;
        rc_set  = rx_acc && (rx_thr != '0) && (nc == int'(rx_thr));
        raw_hit = (rx_thr != '0) && (int'(rx_count_i) >= int'(rx_thr));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            clk_q  <= '0;
            txw_q  <= '0;
            rxw_q  <= '0;
            frm_q  <= '0;
            ie_tc  <= 1'b0;
            ie_rc  <= 1'b0;
            ie_ov  <= 1'b0;
            tx_thr <= '0;
            rx_thr <= '0;
        end else if (wr_en) begin
            unique case (bus_addr_i)
                A_CTRL: en_q  <= bus_wdata_i[0];
                A_CLK:  clk_q <= bus_wdata_i;
                A_TXW:  txw_q <= bus_wdata_i;
                A_RXW:  rxw_q <= bus_wdata_i;
                A_FRM:  frm_q <= bus_wdata_i;
                A_IEN: begin
                    ie_tc <= bus_wdata_i[B_TXC];
                    ie_rc <= bus_wdata_i[B_RXC];
                    ie_ov <= bus_wdata_i[B_OVR];
                end
                A_FCTL: begin
                    tx_thr <= bus_wdata_i[8 +: THR_W];
                    rx_thr <= bus_wdata_i[0 +: THR_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_tc <= 1'b0;
            is_rc <= 1'b0;
            is_ov <= 1'b0;
        end else begin
            if (wr_en && (bus_addr_i == A_IST)) begin
                if (bus_wdata_i[B_TXC]) is_tc <= 1'b0;
                if (bus_wdata_i[B_RXC]) is_rc <= 1'b0;
                if (bus_wdata_i[B_OVR]) is_ov <= 1'b0;
            end
            if (tx_done_i)              is_tc <= 1'b1;
            if (rc_set)                 is_rc <= 1'b1;
            if (rx_valid_i && rx_full_i) is_ov <= 1'b1;
        end
    end

    always_comb begin
        rv = '0;
        unique case (bus_addr_i)
            A_CTRL: rv[0] = en_q;
            A_CLK:  rv = clk_q;
            A_TXW:  rv = txw_q;
            A_RXW:  rv = rxw_q;
            A_FRM:  rv = frm_q;
            A_STAT: rv[0] = !rx_empty_i;
            A_IEN: begin
                rv[B_TXC] = ie_tc;
                rv[B_RXC] = ie_rc;
                rv[B_OVR] = ie_ov;
            end
            A_IST: begin
                rv[B_RAW] = raw_hit;
                rv[B_TXC] = is_tc;
                rv[B_RXC] = is_rc;
                rv[B_OVR] = is_ov;
            end
            A_FCTL: begin
                rv[8 +: THR_W] = tx_thr;
                rv[0 +: THR_W] = rx_thr;
            end
            A_DATA: rv = rx_empty_i ? '0 : rx_head_i;
            default: rv = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bus_rdata_o <= '0;
        else if (rd_en) bus_rdata_o <= rv;
    end

    assign irq_o = (is_tc && ie_tc) || (is_rc && ie_rc) || (is_ov && ie_ov);

    assert_overrun_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_i && rx_full_i |=> is_ov);

    assert_rc_at_threshold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_rc) && $stable(rx_thr) |-> int'(rx_count_i) == int'(rx_thr));

    assert_clear_ovr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (bus_addr_i == A_IST) && bus_wdata_i[B_OVR] && !rx_valid_i |=> !is_ov);
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [shq_pkg::ADDR_W-1:0]  bus_addr,
    input  logic [WIDTH-1:0]            bus_wdata,
    output logic [WIDTH-1:0]            bus_rdata,
    output logic                        sh_tx_valid,
    input  logic                        sh_tx_ready,
    output logic [WIDTH-1:0]            sh_tx_word,
    input  logic                        sh_rx_valid,
    input  logic [WIDTH-1:0]            sh_rx_word,
    output logic                        irq
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic             en;
    logic             tx_push, tx_flush, tx_pop, tx_empty, tx_full;
    logic [CW-1:0]    tx_count;
    logic [WIDTH-1:0] tx_head;
    logic             rx_pop, rx_flush, rx_empty, rx_full;
    logic [CW-1:0]    rx_count;
    logic [WIDTH-1:0] rx_head;
    logic             tx_done;

    shq_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush_i(tx_flush), .push_i(tx_push),
        .pop_i(tx_pop), .din_i(bus_wdata), .dout_o(tx_head),
        .count_o(tx_count), .empty_o(tx_empty), .full_o(tx_full)
    );

    shq_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush_i(rx_flush), .push_i(sh_rx_valid),
        .pop_i(rx_pop), .din_i(sh_rx_word), .dout_o(rx_head),
        .count_o(rx_count), .empty_o(rx_empty), .full_o(rx_full)
    );

    shq_tx_hand #(.WIDTH(WIDTH)) u_hand (
        .clk(clk), .rst_n(rst_n), .en_i(en), .fifo_empty_i(tx_empty),
        .fifo_word_i(tx_head), .fifo_pop_o(tx_pop), .tx_valid_o(sh_tx_valid),
        .tx_word_o(sh_tx_word), .tx_ready_i(sh_tx_ready), .done_o(tx_done)
    );

    shq_csr #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_csr (
        .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .en_o(en), .txf_push_o(tx_push), .txf_flush_o(tx_flush),
        .rxf_pop_o(rx_pop), .rxf_flush_o(rx_flush), .rx_head_i(rx_head),
        .rx_count_i(rx_count), .rx_empty_i(rx_empty), .rx_full_i(rx_full),
        .rx_valid_i(sh_rx_valid), .tx_done_i(tx_done), .irq_o(irq)
    );

    assert_tx_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push && tx_full && !tx_pop |=> $stable(tx_count));
endmodule

// File: tb/spi_host_regs_bench.sv
`timescale 1ns/1ps
module spi_host_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sh_tx_valid, sh_rx_valid, irq;
    logic        sh_tx_ready = 1'b1;
    logic [31:0] sh_tx_word, sh_rx_word;
    logic        eng_v = 1'b0, inj_mode = 1'b0, inj_v = 1'b0;
    logic [31:0] eng_w = '0, inj_w = '0;
    int          total = 0, bad = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        eng_v <= sh_tx_valid && sh_tx_ready;
        eng_w <= sh_tx_word;
    end

    assign sh_rx_valid = inj_mode ? inj_v : eng_v;
    assign sh_rx_word  = inj_mode ? inj_w : eng_w;

    spi_host_regs u_spi_host_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sh_tx_valid(sh_tx_valid), .sh_tx_ready(sh_tx_ready), .sh_tx_word(sh_tx_word),
        .sh_rx_valid(sh_rx_valid), .sh_rx_word(sh_rx_word), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic inject(input logic [31:0] d);
        @(negedge clk);
        inj_v = 1'b1; inj_w = d;
        @(negedge clk);
        inj_v = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(6'h00, v); chk("R1 ctrl reset", v, 32'h0);
        rd(6'h14, v); chk("R6 status reset", v, 32'h0);
        rd(6'h1C, v); chk("R1 istat reset", v, 32'h0);
        chk("R12 irq reset", {31'h0, irq}, 32'h0);

        // R1 storage
        wr(6'h04, 32'h1234_5678); rd(6'h04, v); chk("R1 clock reg", v, 32'h1234_5678);
        wr(6'h10, 32'h8000_4001); rd(6'h10, v); chk("R1 frame reg", v, 32'h8000_4001);
        wr(6'h08, 32'h0000_0D0D); rd(6'h08, v); chk("R1 txword reg", v, 32'h0000_0D0D);
        wr(6'h18, 32'hFFFF_FFFF); rd(6'h18, v); chk("R1 ien mask", v, 32'h19);
        wr(6'h18, 32'h0);
        wr(6'h20, 32'hFFFF_FFFF); rd(6'h20, v); chk("R1 R7 fctl readback", v, 32'h0F0F);
        rd(6'h28, v); chk("R1 unmapped", v, 32'h0);
        wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, v); chk("R1 ctrl enable", v, 32'h1);

        // R5 empty read
        rd(6'h24, v); chk("R5 empty read", v, 32'h0);
        rd(6'h14, v); chk("R5 R6 still empty", v, 32'h0);

        // R3 stall: word held while ready low
        sh_tx_ready = 1'b0;
        wr(6'h24, 32'hCAFE_0001);
        idle(5);
        chk("R3 valid during stall", {31'h0, sh_tx_valid}, 32'h1);
        chk("R3 word during stall", sh_tx_word, 32'hCAFE_0001);
        idle(3);
        chk("R3 word still held", sh_tx_word, 32'hCAFE_0001);
        sh_tx_ready = 1'b1;
        idle(10);
        rd(6'h14, v); chk("R6 status nonempty", v, 32'h1);
        rd(6'h24, v); chk("R3 loopback word", v, 32'hCAFE_0001);
        rd(6'h1C, v); chk("R10 tx complete", v & 32'h10, 32'h10);
        wr(6'h1C, 32'h19); rd(6'h1C, v); chk("R11 cleared", v, 32'h0);

        // R4 enable off
        wr(6'h00, 32'h0);
        for (int i = 0; i < 3; i++) wr(6'h24, 32'hA000_0000 + i);
        idle(20);
        chk("R4 no offer while disabled", {31'h0, sh_tx_valid}, 32'h0);
        rd(6'h14, v); chk("R4 nothing returned", v, 32'h0);
        wr(6'h00, 32'h1);
        idle(20);
        for (int i = 0; i < 3; i++) begin
            rd(6'h24, v); chk("R3 R4 order after enable", v, 32'hA000_0000 + i);
        end

        // R2 transmit FIFO full drops 9th push
        wr(6'h1C, 32'h19);
        wr(6'h00, 32'h0);
        for (int i = 0; i < 9; i++) wr(6'h24, 32'hB000_0000 + i);
        wr(6'h00, 32'h1);
        idle(40);
        for (int i = 0; i < 8; i++) begin
            rd(6'h24, v); chk("R2 R5 drained word", v, 32'hB000_0000 + i);
        end
        rd(6'h24, v); chk("R2 ninth dropped", v, 32'h0);
        rd(6'h1C, v); chk("R2 no overrun", v & 32'h1, 32'h0);

        // R8 threshold sweep
        for (int t = 1; t <= 8; t++) begin
            wr(6'h20, 32'h1010 | (t << 8) | t);
            wr(6'h1C, 32'h19);
            for (int i = 0; i < t - 1; i++) wr(6'h24, (t << 4) + i);
            idle(30);
            rd(6'h1C, v); chk("R8 below threshold", v & 32'h208, 32'h0);
            wr(6'h24, (t << 4) + t - 1);
            idle(30);
            rd(6'h1C, v); chk("R8 threshold reached", v & 32'h208, 32'h208);
            for (int i = 0; i < t; i++) begin
                rd(6'h24, v); chk("R8 R5 burst data", v, (t << 4) + i);
            end
        end

        // R8 threshold zero never fires
        wr(6'h20, 32'h1010);
        wr(6'h1C, 32'h19);
        wr(6'h24, 32'h55);
        idle(20);
        rd(6'h1C, v); chk("R8 zero threshold", v & 32'h208, 32'h0);
        rd(6'h24, v);

        // R12 irq
        wr(6'h20, 32'h1012);
        wr(6'h1C, 32'h19);
        wr(6'h18, 32'h08);
        wr(6'h24, 32'h1); wr(6'h24, 32'h2);
        idle(20);
        chk("R12 irq enabled cause", {31'h0, irq}, 32'h1);
        wr(6'h18, 32'h0);
        chk("R12 irq masked", {31'h0, irq}, 32'h0);
        wr(6'h18, 32'h08);
        chk("R12 irq unmasked", {31'h0, irq}, 32'h1);
        wr(6'h1C, 32'h08);
        chk("R11 R12 irq after clear", {31'h0, irq}, 32'h0);
        rd(6'h1C, v); chk("R11 only bit3 cleared", v, 32'h210);
        wr(6'h18, 32'h0);

        // R9 overrun via injection
        wr(6'h20, 32'h1010);
        wr(6'h1C, 32'h19);
        inj_mode = 1'b1;
        for (int i = 0; i < 9; i++) inject(32'hD000_0000 + i);
        rd(6'h1C, v); chk("R9 overrun set", v & 32'h1, 32'h1);
        wr(6'h1C, 32'h0);
        rd(6'h1C, v); chk("R11 write zero no effect", v & 32'h1, 32'h1);
        wr(6'h18, 32'h01);
        chk("R12 irq overrun", {31'h0, irq}, 32'h1);
        wr(6'h18, 32'h0);
        for (int i = 0; i < 8; i++) begin
            rd(6'h24, v); chk("R9 kept words", v, 32'hD000_0000 + i);
        end
        rd(6'h14, v); chk("R6 R9 empty after drain", v, 32'h0);
        wr(6'h1C, 32'h01);
        rd(6'h1C, v); chk("R11 overrun cleared", v & 32'h1, 32'h0);

        // R7 receive flush
        for (int i = 0; i < 3; i++) inject(32'hE0 + i);
        wr(6'h20, 32'h0010);
        rd(6'h14, v); chk("R7 rx flushed", v, 32'h0);
        rd(6'h24, v); chk("R7 R5 read after flush", v, 32'h0);
        inj_mode = 1'b0;

        // R7 transmit flush
        wr(6'h00, 32'h0);
        wr(6'h24, 32'hF1); wr(6'h24, 32'hF2);
        wr(6'h20, 32'h1305);
        rd(6'h20, v); chk("R7 thresholds kept", v, 32'h0305);
        wr(6'h00, 32'h1);
        idle(20);
        rd(6'h14, v); chk("R7 tx flushed", v, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule